// File: doc/BRIEF.md
# Comparator Event Timer

This block keeps a free-running 64-bit tick counter and a small set of comparator channels, all reached through a plain 32-bit register bus. Software programs each channel with a target count. When the counter reaches that count, the channel raises an event. The event can be a one-cycle pulse or a level that stays high until it is cleared, and a channel may reload itself by a programmed period so that it fires at a steady rate. The bus has a write strobe and a combinational read port. A read has no side effects.

Matching is strict equality. A target that the counter has already passed stays silent until the counter wraps around to it again. In 32-bit mode a channel looks only at the low word of the counter, so it wraps every 2^32 ticks. Writes to a comparator pass through a short internal pipeline before the match logic sees them, so software has to program targets with some margin.

A global replacement switch steers the events of channels 0 and 1 onto two fixed system interrupt lines, a tick line and a clock line. While the switch is set, their ordinary per-channel outputs stay low. Each channel also holds a message data word and a message address word. The block stores these two words and does nothing else with them.

Top module: `cmp_event_timer`

## Requirements
- R1: The register at offset 0x000 reads the channel count minus one in bits [3:0] and a 1 in bit 8, which flags replacement routing. Offset 0x004 reads the tick period parameter in femtoseconds, and writes to it are ignored. Any offset that maps to no register reads 0, including channel offsets 0x04 and channels above the count.
- R2: Bit 0 of the global control register at 0x010 is the run bit. While it is 1 the counter grows by exactly one per clock, and while it is 0 the counter holds its value.
- R3: The counter reads and writes as two words, the low word at 0x030 and the high word at 0x034. A written word appears at the edge of the write and replaces that edge's increment.
- R4: A channel event happens in a cycle where the run bit is 1, the channel enable bit (config bit 1) is 1 and the counter equals the 64-bit comparator. Its edge output goes high at the next edge. A comparator below the counter does not fire until the counter wraps.
- R5: With config bit 4 set, a channel compares only bits [31:0] of the counter with the low comparator word. With bit 4 clear, all 64 bits must match.
- R6: With periodic mode (config bit 2) and value-set (config bit 3) both 1, a write to the low comparator word loads the comparator and clears value-set. Comparator writes made while value-set is 0 load the period instead. On every event, the comparator advances by the period.
- R7: A comparator or period write takes effect two clocks after its write edge, both in readback and in matching.
- R8: The status register at 0x020 holds one bit per channel, with bit i for channel i. A bit is set by that channel's event, and writing 1 to it clears it. An event in the same cycle as the clear wins.
- R9: With config bit 0 clear, the channel output is a one-cycle pulse. With config bit 0 set, the output follows the channel's status bit and stays high until software clears it.
- R10: When bit 1 of 0x010 is set, channel 0's output appears on the tick line and channel 1's output on the clock line, and both per-channel outputs read 0. When bit 1 is clear, both system lines stay low.
- R11: Each channel holds a message data word at offset 0x10 and a message address word at offset 0x14. Each word reads back exactly as written. Channel i's registers sit at 0x100 + 0x20*i, its config at offset 0x00 and its comparator words at 0x08 (low) and 0x0C (high).
- R12: A channel whose enable bit is 0 raises no output and no status bit, even when the counter equals its comparator.
- R13: Config bit 8 reads periodic capability and bit 9 reads message capability, and writes to either bit are ignored. Periodic mode and value-set stay 0 on a channel without periodic capability, and bit 5 (message enable) stays 0 on a channel without message capability. By default channels 0 and 1 have periodic capability and channels 1 and 2 have message capability.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| ch_irq | output | NUM_CH | Per-channel event outputs |
| sys_tick_irq | output | 1 | Replacement line fed by channel 0 |
| sys_clock_irq | output | 1 | Replacement line fed by channel 1 |

## Verification
The match logic is tried with five kinds of target:
- A target ahead of a halted counter tells exact-cycle firing apart from early or late firing.
- A target behind the counter tells equality matching apart from a greater-or-equal test.
- A target across the 32-bit wrap tells a low-word-only match apart from a full 64-bit match.
- A periodic pair of writes tells compare loading apart from period loading.
- Targets one tick apart, written while the counter runs, tell the two-clock write latency apart from a shorter or longer one.

Level and edge outputs, routing with replacement on and off, and disabled channels are then checked against the same counter timeline.

// File: rtl/cet_pkg.sv
package cet_pkg;

    localparam int REG_AW = 10;
    localparam int DW     = 32;
    localparam int CNT_W  = 64;

    // global register offsets
    localparam logic [REG_AW-1:0] A_IDENT  = 10'h000;
    localparam logic [REG_AW-1:0] A_PERIOD = 10'h004;
    localparam logic [REG_AW-1:0] A_GCTL   = 10'h010;
    localparam logic [REG_AW-1:0] A_STATUS = 10'h020;
    localparam logic [REG_AW-1:0] A_CNT_LO = 10'h030;
    localparam logic [REG_AW-1:0] A_CNT_HI = 10'h034;

    // channel region: addr[9:8] == 01, channel index addr[7:5], offset addr[4:0]
    localparam int            CH_IDX_LSB = 5;
    localparam int            CH_IDX_W   = 3;
    localparam logic [1:0]    CH_REGION  = 2'b01;
    localparam logic [4:0]    O_CFG      = 5'h00;
    localparam logic [4:0]    O_CMP_LO   = 5'h08;
    localparam logic [4:0]    O_CMP_HI   = 5'h0C;
    localparam logic [4:0]    O_MSG_LO   = 5'h10;
    localparam logic [4:0]    O_MSG_HI   = 5'h14;

    // global control bits
    localparam int G_RUN    = 0;
    localparam int G_LEGACY = 1;

    // channel config bits
    localparam int B_LEVEL  = 0;
    localparam int B_EN     = 1;
    localparam int B_PER    = 2;
    localparam int B_VSET   = 3;
    localparam int B_W32    = 4;
    localparam int B_MSG    = 5;
    localparam int B_PERCAP = 8;
    localparam int B_MSGCAP = 9;

    typedef struct packed {
        logic level;
        logic en;
        logic periodic;
        logic vset;
        logic w32;
        logic msg_en;
    } ch_cfg_t;

    typedef struct packed {
        logic          vld;
        logic          hi;
        logic          to_per;
        logic [DW-1:0] data;
    } cmp_wr_t;

    function automatic logic [DW-1:0] cfg_pack(ch_cfg_t c, logic pcap, logic mcap);
        logic [DW-1:0] r;
        r           = '0;
        r[B_LEVEL]  = c.level;
        r[B_EN]     = c.en;
        r[B_PER]    = c.periodic;
        r[B_VSET]   = c.vset;
        r[B_W32]    = c.w32;
        r[B_MSG]    = c.msg_en;
        r[B_PERCAP] = pcap;
        r[B_MSGCAP] = mcap;
        return r;
    endfunction

    function automatic ch_cfg_t cfg_unpack(logic [DW-1:0] w, logic pcap, logic mcap);
        ch_cfg_t c;
        c.level    = w[B_LEVEL];
        c.en       = w[B_EN];
        c.periodic = w[B_PER] & pcap;
        c.vset     = w[B_VSET] & pcap;
        c.w32      = w[B_W32];
        c.msg_en   = w[B_MSG] & mcap;
        return c;
    endfunction

endpackage

// File: rtl/cet_counter.sv
module cet_counter
    import cet_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  cnt
);
    localparam int HI_W = W - DW;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (we_lo) begin
            cnt <= {cnt[W-1:DW], wdata};
        end else if (we_hi) begin
            cnt <= {wdata[HI_W-1:0], cnt[DW-1:0]};
        end else if (run) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/cet_channel.sv
module cet_channel
    import cet_pkg::*;
#(
    parameter int CMP_LAT = 2,
    parameter bit PER_CAP = 1'b1,
    parameter bit MSG_CAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic             msg_we,
    input  logic             hi_sel,
    input  logic [DW-1:0]    wdata,
    input  logic             sts_clr,
    output logic [DW-1:0]    cfg_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic [2*DW-1:0]  msg_rd,
    output logic             hit,
    output logic             status,
    output logic             irq
);
    ch_cfg_t                  cfg;
    cmp_wr_t [CMP_LAT-1:0]    pipe;
    cmp_wr_t                  wr_in;
    cmp_wr_t                  wr_out;
    logic [CNT_W-1:0]         cmp_q;
    logic [CNT_W-1:0]         per_q;
    logic [2*DW-1:0]          msg_q;
    logic                     pulse_q;
    logic                     eq;

    // a comparator write picks its target when it is issued
    always_comb begin
        wr_in.vld    = cmp_we;
        wr_in.hi     = hi_sel;
        wr_in.to_per = cfg.periodic & ~cfg.vset;
        wr_in.data   = wdata;
    end

    assign wr_out = pipe[CMP_LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            for (int k = CMP_LAT - 1; k > 0; k--) pipe[k] <= pipe[k-1];
            pipe[0] <= wr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_we) begin
            cfg <= cfg_unpack(wdata, PER_CAP, MSG_CAP);
        end else if (cmp_we && !hi_sel && cfg.periodic && cfg.vset) begin
            cfg.vset <= 1'b0;
        end
    end

    assign eq  = cfg.w32 ? (cnt[DW-1:0] == cmp_q[DW-1:0]) : (cnt == cmp_q);
    assign hit = run & cfg.en & eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            per_q <= '0;
        end else if (wr_out.vld) begin
            if (wr_out.to_per) begin
                if (wr_out.hi) per_q[CNT_W-1:DW] <= wr_out.data;
                else           per_q[DW-1:0]     <= wr_out.data;
            end else begin
                if (wr_out.hi) cmp_q[CNT_W-1:DW] <= wr_out.data;
                else           cmp_q[DW-1:0]     <= wr_out.data;
            end
        end else if (hit && cfg.periodic) begin
            if (cfg.w32) cmp_q[DW-1:0] <= cmp_q[DW-1:0] + per_q[DW-1:0];
            else         cmp_q         <= cmp_q + per_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
        end else if (msg_we) begin
            if (hi_sel) msg_q[2*DW-1:DW] <= wdata;
            else        msg_q[DW-1:0]    <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit)          status <= 1'b1;
            else if (sts_clr) status <= 1'b0;
        end
    end

    assign irq    = cfg.level ? status : pulse_q;
    assign cfg_rd = cfg_pack(cfg, PER_CAP, MSG_CAP);
    assign cmp_rd = cmp_q;
    assign msg_rd = msg_q;
endmodule

// File: rtl/cet_irq_route.sv
module cet_irq_route #(
    parameter int NUM_CH = 3
) (
    input  logic              legacy,
    input  logic [NUM_CH-1:0] irq_in,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              sys_tick_irq,
    output logic              sys_clock_irq
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_route
        if (i < 2) begin : g_steered
            assign ch_irq[i] = irq_in[i] & ~legacy;
        end else begin : g_plain
            assign ch_irq[i] = irq_in[i];
        end
    end

    assign sys_tick_irq  = legacy & irq_in[0];
    assign sys_clock_irq = legacy & irq_in[1];
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
    import cet_pkg::*;
#(
    parameter int          NUM_CH       = 3,
    parameter logic [31:0] PERIOD_FS    = 32'd69841279,
    parameter int          CMP_LAT      = 2,
    parameter logic [7:0]  PER_CAP_MASK = 8'h03,
    parameter logic [7:0]  MSG_CAP_MASK = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [9:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              sys_tick_irq,
    output logic              sys_clock_irq
);
    // NUM_CH must lie in 2..8: two channels feed the replacement lines,
    // three index bits select a channel
    localparam logic [3:0] ID_COUNT = 4'(NUM_CH - 1);

    logic                  run;
    logic                  legacy;
    logic [CNT_W-1:0]      cnt_q;
    logic                  cnt_we_lo, cnt_we_hi, cnt_wr;
    logic                  in_ch;
    logic [CH_IDX_W-1:0]   ch_idx;
    logic [4:0]            ch_off;
    logic [NUM_CH-1:0]     ch_hit, ch_status, ch_irq_raw, sts_clr;
    logic [DW-1:0]         ch_cfg_rd [NUM_CH];
    logic [CNT_W-1:0]      ch_cmp_rd [NUM_CH];
    logic [2*DW-1:0]       ch_msg_rd [NUM_CH];

    assign in_ch  = (reg_addr[9:8] == CH_REGION);
    assign ch_idx = reg_addr[CH_IDX_LSB +: CH_IDX_W];
    assign ch_off = reg_addr[4:0];

    assign cnt_we_lo = reg_we && (reg_addr == A_CNT_LO);
    assign cnt_we_hi = reg_we && (reg_addr == A_CNT_HI);
    assign cnt_wr    = cnt_we_lo | cnt_we_hi;
    assign sts_clr   = (reg_we && reg_addr == A_STATUS) ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            legacy <= 1'b0;
        end else if (reg_we && reg_addr == A_GCTL) begin
            run    <= reg_wdata[G_RUN];
            legacy <= reg_wdata[G_LEGACY];
        end
    end

    cet_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .we_lo (cnt_we_lo),
        .we_hi (cnt_we_hi),
        .wdata (reg_wdata),
        .cnt   (cnt_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = in_ch && (ch_idx == CH_IDX_W'(i));

        cet_channel #(
            .CMP_LAT (CMP_LAT),
            .PER_CAP (PER_CAP_MASK[i]),
            .MSG_CAP (MSG_CAP_MASK[i])
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt_q),
            .run     (run),
            .cfg_we  (reg_we && sel && ch_off == O_CFG),
            .cmp_we  (reg_we && sel && (ch_off == O_CMP_LO || ch_off == O_CMP_HI)),
            .msg_we  (reg_we && sel && (ch_off == O_MSG_LO || ch_off == O_MSG_HI)),
            .hi_sel  (ch_off[2]),
            .wdata   (reg_wdata),
            .sts_clr (sts_clr[i]),
            .cfg_rd  (ch_cfg_rd[i]),
            .cmp_rd  (ch_cmp_rd[i]),
            .msg_rd  (ch_msg_rd[i]),
            .hit     (ch_hit[i]),
            .status  (ch_status[i]),
            .irq     (ch_irq_raw[i])
        );
    end

    cet_irq_route #(.NUM_CH(NUM_CH)) u_route (
        .legacy        (legacy),
        .irq_in        (ch_irq_raw),
        .ch_irq        (ch_irq),
        .sys_tick_irq  (sys_tick_irq),
        .sys_clock_irq (sys_clock_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_ch) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == CH_IDX_W'(i)) begin
                    case (ch_off)
                        O_CFG:    reg_rdata = ch_cfg_rd[i];
                        O_CMP_LO: reg_rdata = ch_cmp_rd[i][DW-1:0];
                        O_CMP_HI: reg_rdata = ch_cmp_rd[i][CNT_W-1:DW];
                        O_MSG_LO: reg_rdata = ch_msg_rd[i][DW-1:0];
                        O_MSG_HI: reg_rdata = ch_msg_rd[i][2*DW-1:DW];
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end else begin
            case (reg_addr)
                A_IDENT:  reg_rdata = {23'd0, 1'b1, 4'd0, ID_COUNT};
                A_PERIOD: reg_rdata = PERIOD_FS;
                A_GCTL:   reg_rdata = {30'd0, legacy, run};
                A_STATUS: reg_rdata = DW'(ch_status);
                A_CNT_LO: reg_rdata = cnt_q[DW-1:0];
                A_CNT_HI: reg_rdata = cnt_q[CNT_W-1:DW];
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cet_checker.sv
module cet_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              legacy,
    input logic              cnt_wr,
    input logic [63:0]       cnt_q,
    input logic [NUM_CH-1:0] ch_hit,
    input logic [NUM_CH-1:0] ch_status,
    input logic [NUM_CH-1:0] ch_irq,
    input logic              sys_tick_irq,
    input logic              sys_clock_irq
);
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1));

    assert_legacy_mask_R10: assert property (@(posedge clk) disable iff (rst)
        legacy |-> (ch_irq[1:0] == 2'b00));

    assert_legacy_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !legacy |-> (!sys_tick_irq && !sys_clock_irq));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_status_cause_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_status[i]) |-> $past(ch_hit[i]));

        assert_hit_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
            ch_hit[i] |-> run);
    end
endmodule

bind cmp_event_timer cet_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .run           (run),
    .legacy        (legacy),
    .cnt_wr        (cnt_wr),
    .cnt_q         (cnt_q),
    .ch_hit        (ch_hit),
    .ch_status     (ch_status),
    .ch_irq        (ch_irq),
    .sys_tick_irq  (sys_tick_irq),
    .sys_clock_irq (sys_clock_irq)
);

// File: tb/sim_cmp_event_timer.sv
`timescale 1ns/100ps
module sim_cmp_event_timer;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic [9:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] ch_irq;
    logic           sys_tick_irq, sys_clock_irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cmp_event_timer u0 (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ch_irq        (ch_irq),
        .sys_tick_irq  (sys_tick_irq),
        .sys_clock_irq (sys_clock_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #0.5;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    function automatic logic src_val(input int s);
        case (s)
            0: return ch_irq[0];
            1: return ch_irq[1];
            2: return ch_irq[2];
            3: return sys_tick_irq;
            default: return sys_clock_irq;
        endcase
    endfunction

    // cycles after the call until the source goes high, 0 if never within maxk
    task automatic wait_src(input int s, input int maxk, output int k);
        k = 0;
        for (int j = 1; j <= maxk; j++) begin
            @(posedge clk); #0.5;
            if (src_val(s)) begin k = j; break; end
        end
    endtask

    task automatic halt_and_zero();
        wr(10'h010, 32'h0);
        wr(10'h030, 32'h0);
        wr(10'h034, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(10'h000, d); chk("R1 ident", d, 32'h102);
        rd(10'h004, d); chk("R1 period", d, 32'd69841279);
        rd(10'h008, d); chk("R1 unmapped global", d, 0);
        rd(10'h104, d); chk("R1 unmapped channel offset", d, 0);
        rd(10'h1E0, d); chk("R1 absent channel", d, 0);
        rd(10'h030, d); chk("R2 counter reset", d, 0);
        rd(10'h020, d); chk("R8 status reset", d, 0);
        chk("R9 outputs reset", {ch_irq, sys_tick_irq, sys_clock_irq}, 0);
        wr(10'h004, 32'h1234);
        rd(10'h004, d); chk("R1 period read-only", d, 32'd69841279);
    endtask

    task automatic t_count();
        logic [31:0] a, b;
        wr(10'h030, 32'h100);
        wr(10'h034, 32'h2);
        rd(10'h030, a); chk("R3 low write", a, 32'h100);
        rd(10'h034, a); chk("R3 high write", a, 32'h2);
        wr(10'h010, 32'h1);
        rd(10'h030, a);
        idle(5);
        rd(10'h030, b); chk("R2 step per clock", b - a, 5);
        wr(10'h010, 32'h0);
        rd(10'h030, a);
        idle(4);
        rd(10'h030, b); chk("R2 hold when stopped", b, a);
    endtask

    task automatic t_oneshot();
        int k; logic [31:0] d;
        halt_and_zero();
        wr(10'h100, 32'h2);
        wr(10'h108, 32'd20);
        wr(10'h10C, 32'd0);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(0, 40, k); chk("R4 fire cycle", k, 21);
        idle(1); chk("R9 edge pulse one cycle", ch_irq[0], 0);
        rd(10'h020, d); chk("R8 status set", d[0], 1);
        wr(10'h020, 32'h1);
        rd(10'h020, d); chk("R8 write one clears", d[0], 0);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_passed();
        int k;
        halt_and_zero();
        wr(10'h030, 32'd100);
        wr(10'h108, 32'd50);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(0, 60, k); chk("R4 passed target silent", k, 0);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_wrap();
        int k;
        halt_and_zero();
        wr(10'h120, 32'h12);
        wr(10'h030, 32'hFFFF_FFF0);
        wr(10'h128, 32'd5);
        wr(10'h12C, 32'd0);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(1, 40, k); chk("R5 low-word match across wrap", k, 22);
        halt_and_zero();
        wr(10'h120, 32'h2);
        wr(10'h030, 32'hFFFF_FFF0);
        wr(10'h010, 32'h1);
        wait_src(1, 40, k); chk("R5 full-width no match", k, 0);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_delay();
        int k; logic [31:0] d;
        halt_and_zero();
        wr(10'h140, 32'h2);
        wr(10'h148, 32'hABCD);
        rd(10'h148, d); chk("R7 not visible at write edge", d, 0);
        @(posedge clk); #0.5;
        rd(10'h148, d); chk("R7 not visible after one clock", d, 0);
        @(posedge clk); #0.5;
        rd(10'h148, d); chk("R7 visible after two clocks", d, 32'hABCD);
        wr(10'h148, 32'h1000);
        idle(3);
        wr(10'h010, 32'h1);
        wr(10'h148, 32'd2);
        wait_src(2, 20, k); chk("R7 target reached before latency", k, 0);
        halt_and_zero();
        wr(10'h148, 32'h1000);
        idle(3);
        wr(10'h020, 32'h7);
        wr(10'h010, 32'h1);
        wr(10'h148, 32'd3);
        wait_src(2, 20, k); chk("R7 target reached after latency", k, 3);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_periodic();
        int k; logic [31:0] d;
        halt_and_zero();
        wr(10'h100, 32'hE);
        rd(10'h100, d); chk("R6 value-set armed", d, 32'h10E);
        wr(10'h108, 32'd10);
        rd(10'h100, d); chk("R6 value-set self-clears", d, 32'h106);
        wr(10'h108, 32'd8);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(0, 40, k); chk("R6 first periodic event", k, 11);
        wait_src(0, 40, k); chk("R6 second interval", k, 8);
        wait_src(0, 40, k); chk("R6 third interval", k, 8);
        wr(10'h010, 32'h0);
        wr(10'h100, 32'h0);
    endtask

    task automatic t_level();
        int k;
        halt_and_zero();
        wr(10'h120, 32'h3);
        wr(10'h128, 32'd6);
        wr(10'h020, 32'h7);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(1, 30, k); chk("R9 level fire cycle", k, 7);
        wr(10'h010, 32'h0);
        idle(5); chk("R9 level holds", ch_irq[1], 1);
        wr(10'h020, 32'h2);
        chk("R9 level released by clear", ch_irq[1], 0);
    endtask

    task automatic t_disabled();
        int k; logic [31:0] d;
        halt_and_zero();
        wr(10'h140, 32'h0);
        wr(10'h148, 32'd5);
        wr(10'h020, 32'h7);
        idle(3);
        wr(10'h010, 32'h1);
        wait_src(2, 20, k); chk("R12 disabled no output", k, 0);
        rd(10'h020, d); chk("R12 disabled no status", d[2], 0);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_legacy();
        int k;
        halt_and_zero();
        wr(10'h020, 32'h7);
        wr(10'h100, 32'h2);
        wr(10'h108, 32'd4);
        idle(3);
        wr(10'h010, 32'h3);
        wait_src(3, 20, k); chk("R10 tick line cycle", k, 5);
        chk("R10 channel 0 masked", ch_irq[0], 0);
        wait_src(4, 20, k); chk("R10 clock line cycle", k, 2);
        chk("R10 channel 1 masked", ch_irq[1], 0);
        wr(10'h010, 32'h0);
        chk("R10 clock line off", sys_clock_irq, 0);
        chk("R10 channel 1 restored", ch_irq[1], 1);
        wr(10'h020, 32'h7);
    endtask

    task automatic t_route_caps();
        logic [31:0] d;
        wr(10'h130, 32'hDEAD_BEEF);
        wr(10'h134, 32'h0000_FEE0);
        rd(10'h130, d); chk("R11 message data", d, 32'hDEAD_BEEF);
        rd(10'h134, d); chk("R11 message address", d, 32'h0000_FEE0);
        rd(10'h110, d); chk("R11 other channel untouched", d, 0);
        wr(10'h140, 32'hFFFF_FFFF);
        rd(10'h140, d); chk("R13 channel 2 caps", d, 32'h233);
        wr(10'h100, 32'h0);
        rd(10'h100, d); chk("R13 channel 0 caps", d, 32'h100);
        wr(10'h140, 32'h0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        idle(1);
        t_reset();
        t_count();
        t_oneshot();
        t_passed();
        t_wrap();
        t_delay();
        t_periodic();
        t_level();
        t_disabled();
        t_legacy();
        t_route_caps();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule